// File: doc/BRIEF.md
# Dual-Lane 8b/10b Receive Decoder

This block turns a 20-bit receive word, carrying two 10-bit line symbols side by side, into two decoded bytes on every clock. Each byte lane has its own decoder slice, and the slices run in parallel. The running disparity is threaded through them. The lower lane starts from the disparity stored at the end of the previous word. The upper lane starts from the disparity that the lower lane's symbol leaves behind. The upper lane's result is stored for the next word.

Every lane reports three flags: a control-character flag, a disparity-error flag and a not-in-table flag. A lane whose symbol is not a legal code word passes the received 10 bits out unchanged, so that downstream logic can log or inspect the raw symbol. A bypass input lets an unencoded stream pass straight through with all flags cleared. Results appear one clock after the word is presented.

Top module: `rx_dual_lane_decoder`

## Requirements
- R1: While reset is asserted, out_valid, out_data and every flag are zero, and the stored running disparity is negative, so the first symbol after reset is judged against negative disparity.
- R2: A valid, non-bypassed word whose lane symbol is a data code word that is legal for that lane's starting disparity yields the decoded byte in the lane's low 8 bits, zeros in its upper 2 bits and all three flags clear, one clock later.
- R3: The twelve control code words (byte values 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD, 0xFE) decode to their byte with the control flag set.
- R4: A symbol that is a legal code word only for the opposite starting disparity is decoded to its byte with the disparity-error flag set.
- R5: A symbol that is not a legal code word for either disparity sets the not-in-table flag, clears the other two flags, and places the received 10 bits unchanged on that lane's 10 data bits.
- R6: The lower lane starts from the stored disparity. The upper lane starts from the disparity left by the lower lane's symbol. The stored disparity takes the upper lane's result after each valid, non-bypassed word.
- R7: The disparity after a symbol is positive if the symbol has more than five ones, negative if it has fewer than five, and unchanged if it has exactly five. This rule also applies to symbols flagged with errors, so an error does not spread to later symbols.
- R8: A valid word with bypass high appears unchanged on out_data one clock later, with all flags zero, and the stored disparity is left unchanged.
- R9: out_valid follows in_valid with one clock of latency. A cycle with in_valid low leaves out_data, the flags and the stored disparity unchanged.
- R10: Lane n occupies bits [10n+9:10n] of in_word and out_data. Within a symbol, bit 0 is the first bit on the line: bits 0 to 5 carry the six-bit sub-block in arrival order, and bits 6 to 9 carry the four-bit sub-block. Decoded byte bit 0 is the least significant data bit. For example, 0x17C is the comma control word 0xBC at negative disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input word is present this cycle |
| in_bypass | input | 1 | Pass the word through without decoding |
| in_word | input | 20 | Two received 10-bit symbols, lane 0 in the low bits |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | 20 | Per lane: decoded byte zero-extended, literal symbol, or bypassed bits |
| out_k | output | 2 | Per-lane control-character flag |
| out_disp_err | output | 2 | Per-lane disparity-error flag |
| out_not_in_table | output | 2 | Per-lane illegal-code flag |

## Verification
Several properties are checked on every cycle:
- out_valid tracks in_valid with one cycle of delay.
- Idle and bypassed cycles leave the stored disparity untouched.
- Idle cycles also leave the outputs untouched, and bypassed words come out bit for bit.
- A not-in-table lane never raises the other two flags.
- Any lane that decodes cleanly has zero upper bits.

The actual byte values, the control flags over all twelve control words, the disparity threading between lanes and across words, and recovery after injected disparity errors can only be shown by the bench's scenarios. The bench builds its own code table and compares against it on every clock.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   localparam int SYM_W  = 10;
   localparam int BYTE_W = 8;

   // six-bit sub-block of the comma control group at negative disparity, bit 0 first on line
   localparam logic [5:0] K28_SIX_NEG = 6'b111100;

   function automatic logic [5:0] rev6(input logic [5:0] s);
      logic [5:0] r;
      for (int i = 0; i < 6; i++) r[i] = s[5-i];
      return r;
   endfunction

   function automatic logic [3:0] rev4(input logic [3:0] s);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = s[3-i];
      return r;
   endfunction

   function automatic int cnt6(input logic [5:0] s);
      return $countones(s);
   endfunction

   function automatic int cnt4(input logic [3:0] s);
      return $countones(s);
   endfunction

   // negative-disparity six-bit forms, written first-bit-left and flipped so bit 0 is first
   function automatic logic [5:0] six_neg(input logic [4:0] x);
      logic [5:0] t;
      case (x)
         5'd0:  t = 6'b100111;  5'd1:  t = 6'b011101;
         5'd2:  t = 6'b101101;  5'd3:  t = 6'b110001;
         5'd4:  t = 6'b110101;  5'd5:  t = 6'b101001;
         5'd6:  t = 6'b011001;  5'd7:  t = 6'b111000;
         5'd8:  t = 6'b111001;  5'd9:  t = 6'b100101;
         5'd10: t = 6'b010101;  5'd11: t = 6'b110100;
         5'd12: t = 6'b001101;  5'd13: t = 6'b101100;
         5'd14: t = 6'b011100;  5'd15: t = 6'b010111;
         5'd16: t = 6'b011011;  5'd17: t = 6'b100011;
         5'd18: t = 6'b010011;  5'd19: t = 6'b110010;
         5'd20: t = 6'b001011;  5'd21: t = 6'b101010;
         5'd22: t = 6'b011010;  5'd23: t = 6'b111010;
         5'd24: t = 6'b110011;  5'd25: t = 6'b100110;
         5'd26: t = 6'b010110;  5'd27: t = 6'b110110;
         5'd28: t = 6'b001110;  5'd29: t = 6'b101110;
         5'd30: t = 6'b011110;  default: t = 6'b101011;
      endcase
      return rev6(t);
   endfunction

   function automatic logic [3:0] four_neg(input logic [2:0] y, input logic alt7);
      logic [3:0] t;
      case (y)
         3'd0: t = 4'b1011;  3'd1: t = 4'b1001;
         3'd2: t = 4'b0101;  3'd3: t = 4'b1100;
         3'd4: t = 4'b1101;  3'd5: t = 4'b1010;
         3'd6: t = 4'b0110;  default: t = alt7 ? 4'b0111 : 4'b1110;
      endcase
      return rev4(t);
   endfunction

   // full encoder, used by the decoder to confirm a candidate against both disparities
   function automatic logic [9:0] enc_symbol(input logic [7:0] b, input logic k, input logic rd);
      logic [4:0] x;
      logic [2:0] y;
      logic [5:0] s;
      logic [3:0] f;
      logic       mid, alt7, k28;
      x    = b[4:0];
      y    = b[7:5];
      k28  = k && (x == 5'd28);
      s    = k28 ? K28_SIX_NEG : six_neg(x);
      if (rd && (cnt6(s) != 3 || x == 5'd7)) s = ~s;
      mid  = (cnt6(s) != 3) ? ~rd : rd;
      alt7 = (y == 3'd7) && (k ||
             (!mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
             ( mid && (x == 5'd11 || x == 5'd13 || x == 5'd14)));
      f    = four_neg(y, alt7);
      if (k28 && cnt4(f) == 2 && y != 3'd3) begin
         if (!mid) f = ~f;
      end else if (mid && (cnt4(f) != 2 || y == 3'd3)) begin
         f = ~f;
      end
      return {f, s};
   endfunction

endpackage

// File: rtl/rxd_lane_slice.sv
module rxd_lane_slice
   import rxd_pkg::*;
(
   input  logic [SYM_W-1:0] sym,
   input  logic             rd_in,
   output logic [SYM_W-1:0] data_o,
   output logic             k_o,
   output logic             derr_o,
   output logic             nit_o,
   output logic             rd_out
);

   localparam int HALF = SYM_W / 2;

   logic [5:0]        six;
   logic [3:0]        four, four_eff;
   logic              hit6, hit4, k28s, a7, kflag;
   logic [4:0]        x;
   logic [2:0]        y;
   logic [BYTE_W-1:0] cand;
   logic [SYM_W-1:0]  code_cur, code_oth;
   logic              legal_cur, legal_oth;
   int                ones;

   assign six  = sym[5:0];
   assign four = sym[9:6];

   // six-bit sub-block search over both disparity forms
   always_comb begin
      hit6 = 1'b0;
      k28s = 1'b0;
      x    = 5'd0;
      for (int v = 0; v < 32; v++) begin
         logic [5:0] c, cp;
         c  = six_neg(5'(v));
         cp = (cnt6(c) != 3 || v == 7) ? ~c : c;
         if (six == c || six == cp) begin
            hit6 = 1'b1;
            x    = 5'(v);
         end
      end
      if (six == K28_SIX_NEG || six == ~K28_SIX_NEG) begin
         hit6 = 1'b1;
         k28s = 1'b1;
         x    = 5'd28;
      end
   end

   // comma group flips its balanced four-bit forms; undo that before lookup
   assign four_eff = (k28s && six == ~K28_SIX_NEG) ? ~four : four;

   always_comb begin
      hit4 = 1'b0;
      a7   = 1'b0;
      y    = 3'd0;
      for (int w = 0; w < 8; w++) begin
         for (int a = 0; a < 2; a++) begin
            logic [3:0] c, cp;
            if (a == 0 || w == 7) begin
               c  = four_neg(3'(w), a[0]);
               cp = (cnt4(c) != 2 || w == 3) ? ~c : c;
               if (four_eff == c || four_eff == cp) begin
                  hit4 = 1'b1;
                  y    = 3'(w);
                  a7   = a[0];
               end
            end
         end
      end
   end

   assign kflag = k28s | (a7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
   assign cand  = {y, x};

   // re-encode the candidate to confirm it and to judge its disparity
   assign code_cur  = enc_symbol(cand, kflag, rd_in);
   assign code_oth  = enc_symbol(cand, kflag, ~rd_in);
   assign legal_cur = hit6 && hit4 && (sym == code_cur);
   assign legal_oth = hit6 && hit4 && (sym == code_oth);

   assign nit_o  = !(legal_cur || legal_oth);
   assign derr_o = !nit_o && !legal_cur;
   assign k_o    = !nit_o && kflag;
   assign data_o = nit_o ? sym : {{(SYM_W-BYTE_W){1'b0}}, cand};

   assign ones   = $countones(sym);
   assign rd_out = (ones > HALF) ? 1'b1 : ((ones < HALF) ? 1'b0 : rd_in);

endmodule

// File: rtl/rxd_out_stage.sv
module rxd_out_stage
   import rxd_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_bypass,
   input  logic [LANES*SYM_W-1:0] raw,
   input  logic [LANES*SYM_W-1:0] dec_data,
   input  logic [LANES-1:0]       dec_k,
   input  logic [LANES-1:0]       dec_derr,
   input  logic [LANES-1:0]       dec_nit,
   output logic                   q_valid,
   output logic [LANES*SYM_W-1:0] q_data,
   output logic [LANES-1:0]       q_k,
   output logic [LANES-1:0]       q_derr,
   output logic [LANES-1:0]       q_nit
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
      end else begin
         q_valid <= in_valid;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_data[g*SYM_W +: SYM_W] <= '0;
            q_k[g]                   <= 1'b0;
            q_derr[g]                <= 1'b0;
            q_nit[g]                 <= 1'b0;
         end else if (in_valid) begin
            if (in_bypass) begin
               q_data[g*SYM_W +: SYM_W] <= raw[g*SYM_W +: SYM_W];
               q_k[g]                   <= 1'b0;
               q_derr[g]                <= 1'b0;
               q_nit[g]                 <= 1'b0;
            end else begin
               q_data[g*SYM_W +: SYM_W] <= dec_data[g*SYM_W +: SYM_W];
               q_k[g]                   <= dec_k[g];
               q_derr[g]                <= dec_derr[g];
               q_nit[g]                 <= dec_nit[g];
            end
         end
      end
   end

endmodule

// File: rtl/rx_dual_lane_decoder.sv
module rx_dual_lane_decoder
   import rxd_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_bypass,
   input  logic [LANES*SYM_W-1:0] in_word,
   output logic                   out_valid,
   output logic [LANES*SYM_W-1:0] out_data,
   output logic [LANES-1:0]       out_k,
   output logic [LANES-1:0]       out_disp_err,
   output logic [LANES-1:0]       out_not_in_table
);

   localparam int W = LANES * SYM_W;

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("rx_dual_lane_decoder: LANES must be 1 to 8");
   end

   logic             rd_q;
   logic [LANES:0]   rd_chain;
   logic [W-1:0]     dec_data;
   logic [LANES-1:0] dec_k, dec_derr, dec_nit;

   assign rd_chain[0] = rd_q;

   for (genvar g = 0; g < LANES; g++) begin : g_slice
      rxd_lane_slice u_slice (
         .sym    (in_word[g*SYM_W +: SYM_W]),
         .rd_in  (rd_chain[g]),
         .data_o (dec_data[g*SYM_W +: SYM_W]),
         .k_o    (dec_k[g]),
         .derr_o (dec_derr[g]),
         .nit_o  (dec_nit[g]),
         .rd_out (rd_chain[g+1])
      );
   end

   // stored disparity: negative after reset, advanced only by decoded words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
      end else if (in_valid && !in_bypass) begin
         rd_q <= rd_chain[LANES];
      end
   end

   rxd_out_stage #(.LANES(LANES)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_bypass(in_bypass),
      .raw      (in_word),
      .dec_data (dec_data),
      .dec_k    (dec_k),
      .dec_derr (dec_derr),
      .dec_nit  (dec_nit),
      .q_valid  (out_valid),
      .q_data   (out_data),
      .q_k      (out_k),
      .q_derr   (out_disp_err),
      .q_nit    (out_not_in_table)
   );

endmodule

// File: rtl/rxd_dec_checker.sv
module rxd_dec_checker #(
   parameter int LANES = 2,
   parameter int SYMW  = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  in_bypass,
   input logic [LANES*SYMW-1:0] in_word,
   input logic                  out_valid,
   input logic [LANES*SYMW-1:0] out_data,
   input logic [LANES-1:0]      out_k,
   input logic [LANES-1:0]      out_disp_err,
   input logic [LANES-1:0]      out_not_in_table,
   input logic                  rd_q
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (out_valid == $past(in_valid)));

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(in_valid)) |-> ($stable(out_data) && $stable(rd_q) && $stable(out_k)));

   assert_bypass_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid && in_bypass)) |->
         (out_data == $past(in_word) && out_k == '0 && out_disp_err == '0 && out_not_in_table == '0));

   assert_bypass_keeps_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid && in_bypass)) |-> $stable(rd_q));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assert_nit_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
         out_not_in_table[g] |-> (!out_k[g] && !out_disp_err[g]));

      assert_clean_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid && !in_bypass) && !out_not_in_table[g]) |->
            (out_data[g*SYMW+SYMW-1 -: 2] == 2'b00));
   end

endmodule

bind rx_dual_lane_decoder rxd_dec_checker #(.LANES(LANES), .SYMW(rxd_pkg::SYM_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .in_bypass       (in_bypass),
   .in_word         (in_word),
   .out_valid       (out_valid),
   .out_data        (out_data),
   .out_k           (out_k),
   .out_disp_err    (out_disp_err),
   .out_not_in_table(out_not_in_table),
   .rd_q            (rd_q)
);

// File: tb/sim_rx_dual_lane_decoder.sv
`timescale 1ns/1ps
module sim_rx_dual_lane_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_bypass = 1'b0;
   logic [19:0] in_word = '0;
   logic        out_valid;
   logic [19:0] out_data;
   logic [1:0]  out_k, out_disp_err, out_not_in_table;

   always #5 clk = ~clk;

   rx_dual_lane_decoder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bypass(in_bypass),
      .in_word(in_word), .out_valid(out_valid), .out_data(out_data),
      .out_k(out_k), .out_disp_err(out_disp_err), .out_not_in_table(out_not_in_table)
   );

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;

   // code table built from the bench's own encoder
   bit  tab_ok  [2][1024];
   int  tab_byte[1024];
   bit  tab_k   [1024];

   // reference model state
   bit          m_rd = 0;
   bit          enc_rd = 0;
   bit          e_valid = 0;
   logic [9:0]  e_data[2];
   bit          e_k[2], e_derr[2], e_nit[2];

   function automatic logic [5:0] flip6(input logic [5:0] s);
      logic [5:0] r;
      for (int i = 0; i < 6; i++) r[i] = s[5-i];
      return r;
   endfunction

   function automatic logic [3:0] flip4(input logic [3:0] s);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = s[3-i];
      return r;
   endfunction

   // encoder: pick the sub-block form that pulls disparity back toward balance
   function automatic logic [9:0] benc(input int b, input bit k, input bit rd);
      logic [5:0] s6;
      logic [3:0] s4;
      int x, y, o;
      bit mid, alt;
      x = b % 32;
      y = b / 32;
      if (k && x == 28) s6 = 6'b001111;
      else case (x)
         0: s6 = 6'b100111;  1: s6 = 6'b011101;  2: s6 = 6'b101101;  3: s6 = 6'b110001;
         4: s6 = 6'b110101;  5: s6 = 6'b101001;  6: s6 = 6'b011001;  7: s6 = 6'b111000;
         8: s6 = 6'b111001;  9: s6 = 6'b100101; 10: s6 = 6'b010101; 11: s6 = 6'b110100;
        12: s6 = 6'b001101; 13: s6 = 6'b101100; 14: s6 = 6'b011100; 15: s6 = 6'b010111;
        16: s6 = 6'b011011; 17: s6 = 6'b100011; 18: s6 = 6'b010011; 19: s6 = 6'b110010;
        20: s6 = 6'b001011; 21: s6 = 6'b101010; 22: s6 = 6'b011010; 23: s6 = 6'b111010;
        24: s6 = 6'b110011; 25: s6 = 6'b100110; 26: s6 = 6'b010110; 27: s6 = 6'b110110;
        28: s6 = 6'b001110; 29: s6 = 6'b101110; 30: s6 = 6'b011110; default: s6 = 6'b101011;
      endcase
      s6 = flip6(s6);
      o = $countones(s6);
      if (x == 7 && !k) begin
         if (rd) s6 = ~s6;
      end else if (o != 3) begin
         if ((o > 3) == rd) s6 = ~s6;
      end
      o = $countones(s6);
      mid = (o > 3) ? 1'b1 : ((o < 3) ? 1'b0 : rd);
      alt = (y == 7) && (k || (!mid && (x == 17 || x == 18 || x == 20)) ||
                             (mid && (x == 11 || x == 13 || x == 14)));
      case (y)
         0: s4 = 4'b1011; 1: s4 = 4'b1001; 2: s4 = 4'b0101; 3: s4 = 4'b1100;
         4: s4 = 4'b1101; 5: s4 = 4'b1010; 6: s4 = 4'b0110;
         default: s4 = alt ? 4'b0111 : 4'b1110;
      endcase
      s4 = flip4(s4);
      o = $countones(s4);
      if (k && x == 28 && o == 2 && y != 3) begin
         if (!mid) s4 = ~s4;
      end else if (o == 2) begin
         if (y == 3 && mid) s4 = ~s4;
      end else if ((o > 2) == mid) begin
         s4 = ~s4;
      end
      return {s4, s6};
   endfunction

   function automatic bit next_rd(input logic [9:0] s, input bit rd);
      int o;
      o = $countones(s);
      if (o > 5) return 1'b1;
      if (o < 5) return 1'b0;
      return rd;
   endfunction

   int klist[12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                     8'hF7, 8'hFB, 8'hFD, 8'hFE};

   task automatic build_table();
      for (int r = 0; r < 2; r++) begin
         for (int b = 0; b < 256; b++) begin
            logic [9:0] c;
            c = benc(b, 1'b0, r[0]);
            tab_ok[r][c] = 1'b1; tab_byte[c] = b; tab_k[c] = 1'b0;
         end
         for (int i = 0; i < 12; i++) begin
            logic [9:0] c;
            c = benc(klist[i], 1'b1, r[0]);
            tab_ok[r][c] = 1'b1; tab_byte[c] = klist[i]; tab_k[c] = 1'b1;
         end
      end
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // apply one word, advance the model, then compare after the edge
   task automatic step(input bit v, input bit byp, input logic [19:0] w, input string tag);
      in_valid = v; in_bypass = byp; in_word = w;
      e_valid = v;
      if (v) begin
         for (int l = 0; l < 2; l++) begin
            logic [9:0] s;
            s = w[l*10 +: 10];
            if (byp) begin
               e_data[l] = s; e_k[l] = 0; e_derr[l] = 0; e_nit[l] = 0;
            end else begin
               if (tab_ok[m_rd][s]) begin
                  e_data[l] = 10'(tab_byte[s]); e_k[l] = tab_k[s]; e_derr[l] = 0; e_nit[l] = 0;
               end else if (tab_ok[!m_rd][s]) begin
                  e_data[l] = 10'(tab_byte[s]); e_k[l] = tab_k[s]; e_derr[l] = 1; e_nit[l] = 0;
               end else begin
                  e_data[l] = s; e_k[l] = 0; e_derr[l] = 0; e_nit[l] = 1;
               end
               m_rd = next_rd(s, m_rd);
            end
         end
      end
      @(posedge clk);
      #2;
      chk(out_valid == e_valid, tag, "out_valid", 32'(out_valid), 32'(e_valid));
      for (int l = 0; l < 2; l++) begin
         logic [12:0] a, e;
         a = {out_data[l*10 +: 10], out_k[l], out_disp_err[l], out_not_in_table[l]};
         e = {e_data[l], e_k[l], e_derr[l], e_nit[l]};
         chk(a == e, tag, $sformatf("lane%0d {data,k,derr,nit}", l), 32'(a), 32'(e));
      end
   endtask

   task automatic send(input int b0, input bit k0, input int b1, input bit k1, input string tag);
      logic [9:0] s0, s1;
      s0 = benc(b0, k0, enc_rd); enc_rd = next_rd(s0, enc_rd);
      s1 = benc(b1, k1, enc_rd); enc_rd = next_rd(s1, enc_rd);
      step(1'b1, 1'b0, {s1, s0}, tag);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < 2; l++) begin
         e_data[l] = '0; e_k[l] = 0; e_derr[l] = 0; e_nit[l] = 0;
      end
      build_table();
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk(out_valid == 0 && out_data == '0 && out_k == '0 && out_disp_err == '0 &&
          out_not_in_table == '0, "R1", "reset outputs",
          {out_valid, out_data, out_k, out_disp_err, out_not_in_table}, 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R10 and R1: comma at negative disparity, bit 0 first on line, in lane 0
      in_valid = 1; in_bypass = 0; in_word = {benc(8'h00, 0, 1'b1), 10'h17C};
      @(posedge clk); #2;
      chk(out_data[9:0] == 10'h0BC && out_k[0] && !out_disp_err[0] && !out_not_in_table[0],
          "R10", "comma 0x17C decode", {out_data[9:0], out_k[0], out_disp_err[0]},
          {10'h0BC, 1'b1, 1'b0});
      chk(out_data[19:10] == 10'h000 && !out_disp_err[1] && !out_k[1], "R6",
          "lane1 starts from lane0 result", {out_data[19:10], out_disp_err[1]}, 32'h0);
      m_rd = next_rd(benc(8'h00, 0, 1'b1), next_rd(10'h17C, 1'b0));
      enc_rd = m_rd;

      // R2 / R6: stream of encoded data
      for (int i = 0; i < 256; i += 2) send(i, 0, i + 1, 0, "R2 R6");
      for (int i = 0; i < 60; i++) send($urandom % 256, 0, $urandom % 256, 0, "R6");

      // R3: all control words in both lanes
      for (int i = 0; i < 12; i++) send(klist[i], 1, klist[11 - i], 1, "R3");

      // R4 / R7: wrong-disparity symbol, then recovery
      for (int i = 0; i < 6; i++) begin
         logic [9:0] bad, good;
         bad = benc(8'h00 + 32 * (i % 2), 0, !m_rd);
         good = benc(8'h07, 0, next_rd(bad, m_rd));
         step(1'b1, 1'b0, {good, bad}, "R4");
         enc_rd = m_rd;
         send(8'h55, 0, 8'hA3, 0, "R7");
         send(8'h0F, 0, 8'hF0, 0, "R7");
      end

      // R5: illegal symbols
      step(1'b1, 1'b0, {10'h3FF, 10'h000}, "R5");
      step(1'b1, 1'b0, {10'h2AA ^ 10'h3C0, 10'h3C0}, "R5");
      for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 20'($urandom), "R5");
      enc_rd = m_rd;

      // R8: bypass, then decoding continues from the held disparity
      step(1'b1, 1'b1, 20'hFFFFF, "R8");
      step(1'b1, 1'b1, 20'h12345, "R8");
      send(8'hBC, 1, 8'h4A, 0, "R8");

      // R9: idle cycles hold outputs and disparity
      step(1'b0, 1'b0, 20'h3FFFF, "R9");
      step(1'b0, 1'b1, 20'h00000, "R9");
      send(8'h11, 0, 8'hFD, 1, "R9");

      // mixed traffic
      for (int i = 0; i < 150; i++) begin
         int sel;
         sel = $urandom % 10;
         if (sel < 6) send($urandom % 256, 0, $urandom % 256, 0, "R2");
         else if (sel == 6) step(1'b0, 1'b0, 20'($urandom), "R9");
         else if (sel == 7) step(1'b1, 1'b1, 20'($urandom), "R8");
         else begin
            step(1'b1, 1'b0, 20'($urandom), "R5");
            enc_rd = m_rd;
         end
      end

      in_valid = 0;
      repeat (2) @(posedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule